// File: doc/BRIEF.md
# Dual-Ring Timeslot Sample Mover

The block shuttles byte samples for two serial-link channels between a 32-bit word memory and a pair of byte lanes. Two circular rings live in that memory. The transmit ring is only read: each word it yields is split into one byte per channel and presented on the transmit lanes. The receive ring is only written: the two bytes on the receive lanes are packed into one word and stored. Both channels share the same ring word. Channel 0 sits in bits 7:0 and channel 1 in bits 15:8. Bits 31:16 of a stored receive word are written as zero.

Software programs each ring with three word addresses: a first address, a half-way address and a last address. It also sets an interrupt mask, then sets the run bit. From then on, every frame strobe moves exactly one word in each direction. After each move, both current pointers step forward, and a pointer that has just used its last address returns to its first address. Whenever the word just moved sits at a ring's half-way or last address, the matching status bit is set. The interrupt line is high while any status bit is set and unmasked.

A sequencer with three states runs each transfer. MV_IDLE waits for a strobe. The transition IDLE→FETCH is taken on a strobe while the run bit is 1; it captures the receive bytes. FETCH reads the transmit word and always moves on to STORE (FETCH→STORE). STORE writes the receive word, latches the transmit bytes, steps both pointers and sets the status bits, then returns to idle (STORE→IDLE). Register offsets are word indices on a 4-bit register address: 0 control (bit 0 = run), 1 status, 2 mask, 4/5/6/7 transmit first/half/last/pointer, 8/9/10/11 receive first/half/last/pointer.

Top module: `sample_mover`

## Requirements
- R1: After reset every register reads zero, `irq` and `tx_valid` are low and both transmit lanes are zero.
- R2: The first, half-way and last registers of both rings read back what was written. The mask register keeps bits 5:0, and the control register keeps bit 0 (run).
- R3: Writing run=1 while run is 0 loads each ring pointer from its first address.
- R4: A strobe sampled at a clock edge while idle and running starts a transfer. After the second following edge, `tx_ch0` equals bits 7:0 and `tx_ch1` bits 15:8 of the transmit word at the transmit pointer, and `tx_valid` is high for exactly one cycle.
- R5: The receive bytes sampled with the strobe are written to the word at the receive pointer as {16'h0, ch1, ch0}, within the same two edges.
- R6: Each transfer advances each pointer by one word. A pointer that equals its last address reloads its first address instead.
- R7: Status bit 0 is set when the transmit word moved came from the transmit last address. Bit 1 is set for the transmit half-way address, bit 2 for the receive last address and bit 3 for the receive half-way address. Status bits 31:4 read zero.
- R8: Writing the status register clears the bits written as 1 and leaves the others. A bit being set in the same cycle as it is cleared stays set.
- R9: `irq` is high exactly when some status bit is set and its mask bit is 1.
- R10: While run is 0, strobes start no memory access and leave both pointers unchanged.
- R11: Writes to the two pointer registers are ignored.
- R12: A strobe still high while a transfer is in progress does not start a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| frame_stb | input | 1 | One transfer per strobe |
| rx_ch0 | input | 8 | Receive sample, channel 0 |
| rx_ch1 | input | 8 | Receive sample, channel 1 |
| tx_ch0 | output | 8 | Transmit sample, channel 0 |
| tx_ch1 | output | 8 | Transmit sample, channel 1 |
| tx_valid | output | 1 | One-cycle pulse when new transmit samples appear |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the access |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven by a long run of strobes with random receive bytes, over two short rings that wrap several times. This shows whether the half-way and last hits, and the wrap back to the first address, happen on the right word. Status clears with random masks, some timed on the very cycle a bit is set, separate sticky, cleared and set-wins behaviour. Random mask values tell `irq` gating apart from raw status. Directed cases cover strobes while stopped, an over-long strobe and writes to the read-only pointers.

// File: rtl/sample_mover_pkg.sv
package sample_mover_pkg;

    localparam int REG_AW  = 4;
    localparam int LANE_W  = 8;
    localparam int N_LANES = 2;
    localparam int STAT_W  = 4;
    localparam int MASK_W  = 6;

    localparam logic [REG_AW-1:0] RA_CTRL     = 4'd0;
    localparam logic [REG_AW-1:0] RA_STAT     = 4'd1;
    localparam logic [REG_AW-1:0] RA_MASK     = 4'd2;
    localparam logic [REG_AW-1:0] RA_TX_FIRST = 4'd4;
    localparam logic [REG_AW-1:0] RA_TX_HALF  = 4'd5;
    localparam logic [REG_AW-1:0] RA_TX_LAST  = 4'd6;
    localparam logic [REG_AW-1:0] RA_TX_PTR   = 4'd7;
    localparam logic [REG_AW-1:0] RA_RX_FIRST = 4'd8;
    localparam logic [REG_AW-1:0] RA_RX_HALF  = 4'd9;
    localparam logic [REG_AW-1:0] RA_RX_LAST  = 4'd10;
    localparam logic [REG_AW-1:0] RA_RX_PTR   = 4'd11;

    localparam int ST_TX_LAST = 0;
    localparam int ST_TX_HALF = 1;
    localparam int ST_RX_LAST = 2;
    localparam int ST_RX_HALF = 3;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_FETCH = 2'd1,
        MV_STORE = 2'd2
    } mv_state_t;

endpackage

// File: rtl/ring_cursor.sv
module ring_cursor #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [PW-1:0] first_a,
    input  logic [PW-1:0] half_a,
    input  logic [PW-1:0] last_a,
    output logic [PW-1:0] cur,
    output logic          at_half,
    output logic          at_last
);

    assign at_last = (cur == last_a);
    assign at_half = (cur == half_a);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= first_a;
        end else if (step) begin
            cur <= at_last ? first_a : cur + PW'(1);
        end
    end

    // R6
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_last) |=> (cur == $past(first_a)));

    // R6
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !at_last) |=> (cur == $past(cur) + PW'(1)));

    // R3
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(first_a)));

endmodule

// File: rtl/mover_regs.sv
module mover_regs
    import sample_mover_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PW-1:0]     tx_cur,
    input  logic [PW-1:0]     rx_cur,
    input  logic [STAT_W-1:0] stat_set,
    output logic              run,
    output logic              arm,
    output logic [PW-1:0]     tx_first,
    output logic [PW-1:0]     tx_half,
    output logic [PW-1:0]     tx_last,
    output logic [PW-1:0]     rx_first,
    output logic [PW-1:0]     rx_half,
    output logic [PW-1:0]     rx_last,
    output logic              irq
);

    logic [STAT_W-1:0] stat;
    logic [STAT_W-1:0] stat_clr;
    logic [MASK_W-1:0] mask;
    logic              wr_ctrl;

    assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
    assign arm      = wr_ctrl && reg_wdata[0] && !run;
    assign stat_clr = (reg_wr && (reg_addr == RA_STAT)) ? reg_wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            mask     <= '0;
            stat     <= '0;
            tx_first <= '0;
            tx_half  <= '0;
            tx_last  <= '0;
            rx_first <= '0;
            rx_half  <= '0;
            rx_last  <= '0;
        end else begin
            stat <= (stat & ~stat_clr) | stat_set;
            if (reg_wr) begin
                unique case (reg_addr)
                    RA_CTRL:     run      <= reg_wdata[0];
                    RA_MASK:     mask     <= reg_wdata[MASK_W-1:0];
                    RA_TX_FIRST: tx_first <= reg_wdata[PW-1:0];
                    RA_TX_HALF:  tx_half  <= reg_wdata[PW-1:0];
                    RA_TX_LAST:  tx_last  <= reg_wdata[PW-1:0];
                    RA_RX_FIRST: rx_first <= reg_wdata[PW-1:0];
                    RA_RX_HALF:  rx_half  <= reg_wdata[PW-1:0];
                    RA_RX_LAST:  rx_last  <= reg_wdata[PW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL:     reg_rdata[0]          = run;
            RA_STAT:     reg_rdata[STAT_W-1:0] = stat;
            RA_MASK:     reg_rdata[MASK_W-1:0] = mask;
            RA_TX_FIRST: reg_rdata[PW-1:0]     = tx_first;
            RA_TX_HALF:  reg_rdata[PW-1:0]     = tx_half;
            RA_TX_LAST:  reg_rdata[PW-1:0]     = tx_last;
            RA_TX_PTR:   reg_rdata[PW-1:0]     = tx_cur;
            RA_RX_FIRST: reg_rdata[PW-1:0]     = rx_first;
            RA_RX_HALF:  reg_rdata[PW-1:0]     = rx_half;
            RA_RX_LAST:  reg_rdata[PW-1:0]     = rx_last;
            RA_RX_PTR:   reg_rdata[PW-1:0]     = rx_cur;
            default:     reg_rdata             = '0;
        endcase
    end

    assign irq = |({{(MASK_W-STAT_W){1'b0}}, stat} & mask);

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ($past(stat) & ~$past(stat_clr))) == ($past(stat) & ~$past(stat_clr))));

    // R8
    stat_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_set) |=> ((stat & $past(stat_set)) == $past(stat_set)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> !irq);

endmodule

// File: rtl/mover_seq.sv
module mover_seq
    import sample_mover_pkg::*;
#(
    parameter int PW = 32,
    parameter int AW = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      frame_stb,
    input  logic [N_LANES*LANE_W-1:0] rx_lanes,
    input  logic [PW-1:0]             tx_cur,
    input  logic [PW-1:0]             rx_cur,
    input  logic                      tx_at_half,
    input  logic                      tx_at_last,
    input  logic                      rx_at_half,
    input  logic                      rx_at_last,
    input  logic [31:0]               mem_rdata,
    output logic                      mem_en,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr,
    output logic [31:0]               mem_wdata,
    output logic [N_LANES*LANE_W-1:0] tx_lanes,
    output logic                      tx_valid,
    output logic                      step,
    output logic [STAT_W-1:0]         stat_set
);

    localparam int LANES_W = N_LANES * LANE_W;

    mv_state_t           state, nxt;
    logic [LANES_W-1:0]  rx_hold;
    logic                start_ok;

    assign start_ok = run && frame_stb;

    always_comb begin
        nxt = state;
        unique case (state)
            MV_IDLE:  nxt = start_ok ? MV_FETCH : MV_IDLE;
            MV_FETCH: nxt = MV_STORE;
            MV_STORE: nxt = MV_IDLE;
            default:  nxt = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MV_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = tx_cur[AW-1:0];
        step      = 1'b0;
        stat_set  = '0;
        unique case (state)
            MV_IDLE: ;
            MV_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = tx_cur[AW-1:0];
            end
            MV_STORE: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = rx_cur[AW-1:0];
                step     = 1'b1;
                stat_set[ST_TX_LAST] = tx_at_last;
                stat_set[ST_TX_HALF] = tx_at_half;
                stat_set[ST_RX_LAST] = rx_at_last;
                stat_set[ST_RX_HALF] = rx_at_half;
            end
            default: ;
        endcase
    end

    assign mem_wdata = {{(32-LANES_W){1'b0}}, rx_hold};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_hold[g*LANE_W +: LANE_W]  <= '0;
                tx_lanes[g*LANE_W +: LANE_W] <= '0;
            end else begin
                if (state == MV_IDLE && start_ok)
                    rx_hold[g*LANE_W +: LANE_W] <= rx_lanes[g*LANE_W +: LANE_W];
                if (state == MV_STORE)
                    tx_lanes[g*LANE_W +: LANE_W] <= mem_rdata[g*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_valid <= 1'b0;
        else        tx_valid <= (state == MV_STORE);
    end

    // R10
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && state == MV_IDLE) |=> !mem_en);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R5
    store_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_en) && !$past(mem_we)));

    // R12
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

endmodule

// File: rtl/sample_mover.sv
module sample_mover
    import sample_mover_pkg::*;
#(
    parameter int AW = 9,
    parameter int PW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_stb,
    input  logic [LANE_W-1:0] rx_ch0,
    input  logic [LANE_W-1:0] rx_ch1,
    output logic [LANE_W-1:0] tx_ch0,
    output logic [LANE_W-1:0] tx_ch1,
    output logic              tx_valid,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);

    localparam int LANES_W = N_LANES * LANE_W;

    logic              run, arm, step;
    logic [PW-1:0]     tx_first, tx_half, tx_last, rx_first, rx_half, rx_last;
    logic [PW-1:0]     tx_cur, rx_cur;
    logic              tx_at_half, tx_at_last, rx_at_half, rx_at_last;
    logic [STAT_W-1:0] stat_set;
    logic [LANES_W-1:0] tx_lanes;

    mover_regs #(.PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_cur(tx_cur), .rx_cur(rx_cur), .stat_set(stat_set),
        .run(run), .arm(arm),
        .tx_first(tx_first), .tx_half(tx_half), .tx_last(tx_last),
        .rx_first(rx_first), .rx_half(rx_half), .rx_last(rx_last),
        .irq(irq)
    );

    ring_cursor #(.PW(PW)) u_tx_ring (
        .clk(clk), .rst_n(rst_n), .load(arm), .step(step),
        .first_a(tx_first), .half_a(tx_half), .last_a(tx_last),
        .cur(tx_cur), .at_half(tx_at_half), .at_last(tx_at_last)
    );

    ring_cursor #(.PW(PW)) u_rx_ring (
        .clk(clk), .rst_n(rst_n), .load(arm), .step(step),
        .first_a(rx_first), .half_a(rx_half), .last_a(rx_last),
        .cur(rx_cur), .at_half(rx_at_half), .at_last(rx_at_last)
    );

    mover_seq #(.PW(PW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .frame_stb(frame_stb),
        .rx_lanes({rx_ch1, rx_ch0}),
        .tx_cur(tx_cur), .rx_cur(rx_cur),
        .tx_at_half(tx_at_half), .tx_at_last(tx_at_last),
        .rx_at_half(rx_at_half), .rx_at_last(rx_at_last),
        .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .tx_lanes(tx_lanes), .tx_valid(tx_valid),
        .step(step), .stat_set(stat_set)
    );

    assign tx_ch0 = tx_lanes[LANE_W-1:0];
    assign tx_ch1 = tx_lanes[2*LANE_W-1:LANE_W];

endmodule

// File: tb/test_sample_mover.sv
module test_sample_mover;

    localparam int AW = 9;
    localparam logic [31:0] TXF = 32'd16, TXH = 32'd19, TXL = 32'd23;
    localparam logic [31:0] RXF = 32'd100, RXH = 32'd103, RXL = 32'd107;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_stb = 1'b0;
    logic [7:0]  rx_ch0 = '0, rx_ch1 = '0;
    logic [7:0]  tx_ch0, tx_ch1;
    logic        tx_valid, mem_en, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] ram [0:(1<<AW)-1];
    int checks = 0, errors = 0, accesses = 0;
    logic [31:0] exp_tp, exp_rp;
    logic [3:0]  exp_stat;
    logic [5:0]  cur_mask;

    sample_mover #(.AW(AW)) i_sample_mover (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_stb(frame_stb),
        .rx_ch0(rx_ch0), .rx_ch1(rx_ch1), .tx_ch0(tx_ch0), .tx_ch1(tx_ch1),
        .tx_valid(tx_valid), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_en) begin
            accesses <= accesses + 1;
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    function automatic logic [31:0] next_ptr(input logic [31:0] p, input logic [31:0] f,
                                             input logic [31:0] l);
        return (p == l) ? f : p + 32'd1;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // One transfer; optional status clear timed on the store edge; optional long strobe.
    task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic do_clr,
                        input logic [3:0] clr, input logic long_stb);
        logic [31:0] d;
        logic [31:0] txw;
        logic [3:0]  setb;
        @(negedge clk);
        frame_stb = 1'b1; rx_ch0 = b0; rx_ch1 = b1;
        @(posedge clk);
        @(negedge clk);
        frame_stb = long_stb;
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
        if (do_clr) begin reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = {28'h0, clr}; end
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        txw = ram[exp_tp[AW-1:0]];
        setb = {exp_rp == RXH, exp_rp == RXL, exp_tp == TXH, exp_tp == TXL};
        chk("R4 tx_ch0", {24'h0, tx_ch0}, {24'h0, txw[7:0]});
        chk("R4 tx_ch1", {24'h0, tx_ch1}, {24'h0, txw[15:8]});
        chk("R4 tx_valid", {31'h0, tx_valid}, 32'd1);
        chk("R5 rx word", ram[exp_rp[AW-1:0]], {16'h0, b1, b0});
        exp_tp = next_ptr(exp_tp, TXF, TXL);
        exp_rp = next_ptr(exp_rp, RXF, RXL);
        exp_stat = (exp_stat & ~(do_clr ? clr : 4'h0)) | setb;
        rd(4'd7, d);  chk("R6 tx pointer", d, exp_tp);
        rd(4'd11, d); chk("R6 rx pointer", d, exp_rp);
        rd(4'd1, d);  chk("R7 R8 status", d, {28'h0, exp_stat});
        chk("R9 irq", {31'h0, irq}, {31'h0, |({2'b00, exp_stat} & cur_mask)});
        @(negedge clk);
        chk("R4 tx_valid drop", {31'h0, tx_valid}, 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        int acc0;
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) ram[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rd(4'd0, d);  chk("R1 ctrl", d, 0);
        rd(4'd1, d);  chk("R1 status", d, 0);
        rd(4'd2, d);  chk("R1 mask", d, 0);
        rd(4'd7, d);  chk("R1 tx pointer", d, 0);
        rd(4'd11, d); chk("R1 rx pointer", d, 0);
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 tx_valid", {31'h0, tx_valid}, 0);
        chk("R1 tx lanes", {16'h0, tx_ch1, tx_ch0}, 0);
        // R2
        wr(4'd4, TXF); wr(4'd5, TXH); wr(4'd6, TXL);
        wr(4'd8, RXF); wr(4'd9, RXH); wr(4'd10, RXL);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd4, d);  chk("R2 tx first", d, TXF);
        rd(4'd6, d);  chk("R2 tx last", d, TXL);
        rd(4'd9, d);  chk("R2 rx half", d, RXH);
        rd(4'd10, d); chk("R2 rx last", d, RXL);
        rd(4'd2, d);  chk("R2 mask", d, 32'h3f);
        cur_mask = 6'h3f;
        // R11
        wr(4'd7, 32'h55); wr(4'd11, 32'h77);
        rd(4'd7, d);  chk("R11 tx pointer ro", d, 0);
        rd(4'd11, d); chk("R11 rx pointer ro", d, 0);
        // R10 stopped: strobe ignored
        acc0 = accesses;
        @(negedge clk); frame_stb = 1'b1;
        repeat (4) @(negedge clk);
        frame_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 no access while stopped", accesses, acc0);
        rd(4'd7, d); chk("R10 pointer held", d, 0);
        // R3
        wr(4'd0, 32'h1);
        rd(4'd0, d);  chk("R2 run bit", d, 1);
        rd(4'd7, d);  chk("R3 tx load", d, TXF);
        rd(4'd11, d); chk("R3 rx load", d, RXF);
        exp_tp = TXF; exp_rp = RXF; exp_stat = 4'h0;
        // random stream with random clears and masks
        for (int n = 0; n < 40; n++) begin
            logic dc;
            logic [3:0] cm;
            dc = ($urandom % 3) == 0;
            cm = 4'($urandom);
            if (($urandom % 5) == 0) begin
                cur_mask = 6'($urandom);
                wr(4'd2, {26'h0, cur_mask});
            end
            xfer(8'($urandom), 8'($urandom), dc, cm, 1'b0);
        end
        // R8 directed: clear bit 0 on the very edge it is set again
        while (exp_tp != TXL) xfer(8'($urandom), 8'($urandom), 1'b0, 4'h0, 1'b0);
        xfer(8'hA5, 8'h5A, 1'b1, 4'hF, 1'b0);
        rd(4'd1, d); chk("R8 set wins over clear", {31'h0, d[0]}, 32'd1);
        // R8 plain clear of everything, nothing set next
        wr(4'd1, 32'hF); exp_stat = 4'h0;
        rd(4'd1, d); chk("R8 write one clears", d, 0);
        wr(4'd1, 32'h0);
        // R12 long strobe gives one transfer
        xfer(8'h12, 8'h34, 1'b0, 4'h0, 1'b1);
        repeat (3) @(negedge clk);
        rd(4'd7, d); chk("R12 single step", d, exp_tp);
        // R10 stop after run cleared
        wr(4'd0, 32'h0);
        acc0 = accesses;
        @(negedge clk); frame_stb = 1'b1;
        @(negedge clk); frame_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 stopped again", accesses, acc0);
        rd(4'd11, d); chk("R10 rx pointer held", d, exp_rp);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule